// File: doc/BRIEF.md
# Byte-Port Sample FIFO with Threshold Events

This block sits between an acquisition converter and a host that can only move one byte per access. Each 16-bit sample from the converter is stored in a buffer of 4096 bytes (2048 samples). The host drains a sample by reading the data address twice. The first read returns the low byte and the second returns the high byte and retires the sample.

The same data address, when written, carries threshold configuration. After a buffer reset, the first four byte writes are consumed as two 16-bit thresholds. Near-empty is written first and is accepted but unused. Near-full follows. The near-full value counts the free bytes left in the buffer, not the bytes held. The status address reports level flags and three sticky events, which clear when status is read. The interrupt output combines the enabled events.

The parameter `DEPTH_BYTES` sets the capacity in bytes. It must be twice a power of two.

Top module: `sample_byte_fifo`

## Requirements
- R1: After `rst`, a status read returns 0x81 (idle and empty set) with `acq_running` low, and `irq` is low.
- R2: Samples leave in arrival order. Each sample takes two data-address reads (`host_sel`=0): the low byte first, then the high byte.
- R3: The buffer holds 2048 samples. With 2048 stored, status bit2 (full) is set. A sample that arrives while full is discarded, the stored contents are unchanged, and status bit5 (data lost) is set.
- R4: After a reset, the first four data-address writes load, in this order: the near-empty low byte, the near-empty high byte, the near-full low byte and the near-full high byte. Further data-address writes are ignored.
- R5: Status bit1 (near full) is set while the free byte count is less than or equal to the near-full threshold. Free bytes are 4096 minus the stored bytes, and a sample whose low byte has already been read counts as one byte. The threshold is 0 after `rst`.
- R6: Status bit3 (threshold event) is set one cycle after near full changes from clear to set.
- R7: Bits 5, 4 and 3 of status are sticky and clear on a status read. An event raised in the same cycle as that read stays set.
- R8: `irq` is high when (control bit3 and threshold event) or (control bit4 and end-of-scan event). Data lost never raises `irq`. A control write (`host_sel`=1) stores bits 3 and 4.
- R9: A `fifo_flush` pulse empties the buffer, returns reads to the low byte and restarts the four-write threshold sequence. The thresholds keep their values until they are rewritten.
- R10: A data-address read while the buffer is empty returns 0x00 and changes no state.
- R11: Status bit6 follows `acq_running`, and bit7 is its inverse.
- R12: A `scan_end` pulse sets status bit4 (end of scan).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_flush | input | 1 | Buffer reset strobe |
| acq_running | input | 1 | Converter acquisition in progress |
| smp_valid | input | 1 | Sample strobe from converter |
| smp_data | input | 16 | Sample value |
| scan_end | input | 1 | End-of-scan pulse from converter |
| host_sel | input | 1 | 0 = data address, 1 = status/control address |
| host_rd | input | 1 | Host byte read |
| host_wr | input | 1 | Host byte write |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid in the read cycle |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the buffer to exactly 2048 samples and then offers one more. A design with an off-by-one full test would either overwrite the oldest sample or refuse the last legal one, and the scoreboard drain would show this. It sets a near-full threshold of 6 free bytes short of capacity and reads half of a sample at the crossing point. A design that counted whole samples would keep near full set when it should drop, and would miss the re-crossing. It raises end of scan in the same cycle as a status read, which catches a clear that wins over a set. It also writes surplus threshold bytes, and flushes while a sample is half read, to expose a config sequencer that wraps around and a byte phase that survives the flush.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int SMP_W = 16;
    localparam int THR_W = 16;

    localparam int CTRL_FIFO_IE_BIT = 3;
    localparam int CTRL_EOS_IE_BIT  = 4;

    // Status byte, MSB first
    typedef struct packed {
        logic idle;
        logic running;
        logic lost;
        logic eos;
        logic thr;
        logic full;
        logic nfull;
        logic empty;
    } stat_t;

    typedef struct packed {
        logic lost;
        logic eos;
        logic thr;
    } evt_t;

    typedef enum logic [2:0] {
        CFG_NE_LO = 3'd0,
        CFG_NE_HI = 3'd1,
        CFG_NF_LO = 3'd2,
        CFG_NF_HI = 3'd3,
        CFG_DONE  = 3'd4
    } cfg_phase_e;

    function automatic logic [7:0] pick_byte(input logic [SMP_W-1:0] w, input logic hi);
        return hi ? w[15:8] : w[7:0];
    endfunction

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store
    import sfifo_pkg::*;
#(
    parameter  int DEPTH_BYTES = 4096,
    localparam int SMP_DEPTH   = DEPTH_BYTES / 2,
    localparam int AW          = $clog2(SMP_DEPTH),
    localparam int CW          = AW + 1,
    localparam int BW          = CW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [SMP_W-1:0] push_data,
    input  logic             pop_byte,
    output logic [7:0]       rd_byte,
    output logic             empty,
    output logic             full,
    output logic             drop,
    output logic [BW-1:0]    used_bytes
);

    logic [SMP_W-1:0] mem [SMP_DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             hi_phase;
    logic             do_push, byte_take, do_pop;

    assign full      = (count == CW'(SMP_DEPTH));
    assign empty     = (count == '0);
    assign do_push   = push && !full;
    assign drop      = push && full;
    assign byte_take = pop_byte && !empty;
    assign do_pop    = byte_take && hi_phase;

    assign used_bytes = {count, 1'b0} - BW'(hi_phase);
    assign rd_byte    = empty ? 8'h00 : pick_byte(mem[rd_ptr], hi_phase);

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            hi_phase <= 1'b0;
        end else begin
            if (do_push)   wr_ptr   <= wr_ptr + 1'b1;
            if (do_pop)    rd_ptr   <= rd_ptr + 1'b1;
            if (byte_take) hi_phase <= ~hi_phase;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(SMP_DEPTH));

    // R3
    drop_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop_byte && !flush) |=> (count == $past(count)));

    // R10
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_byte && empty && !push && !flush) |=> (empty && !hi_phase));

endmodule

// File: rtl/sfifo_thresh.sv
module sfifo_thresh
    import sfifo_pkg::*;
#(
    parameter  int DEPTH_BYTES = 4096,
    localparam int BW          = $clog2(DEPTH_BYTES / 2) + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr,
    input  logic [7:0]    wdata,
    input  logic [BW-1:0] used_bytes,
    output logic          near_full
);

    cfg_phase_e       ph;
    logic [THR_W-1:0] nf_thr;
    logic [THR_W-1:0] free_bytes;

    assign free_bytes = THR_W'(DEPTH_BYTES) - THR_W'(used_bytes);
    assign near_full  = (free_bytes <= nf_thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= CFG_NE_LO;
            nf_thr <= '0;
        end else if (flush) begin
            ph <= CFG_NE_LO;
        end else if (wr && ph != CFG_DONE) begin
            case (ph)
                CFG_NF_LO: nf_thr[7:0]  <= wdata;
                CFG_NF_HI: nf_thr[15:8] <= wdata;
                default:   ;
            endcase
            ph <= cfg_phase_e'(ph + 3'd1);
        end
    end

    // R4
    cfg_done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == CFG_DONE && wr && !flush) |=> (ph == CFG_DONE && $stable(nf_thr)));

endmodule

// File: rtl/sfifo_events.sv
module sfifo_events
    import sfifo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic near_full,
    input  logic drop,
    input  logic eos_in,
    input  logic stat_rd,
    input  logic fifo_ie,
    input  logic eos_ie,
    output evt_t evt,
    output logic irq
);

    logic nf_q;
    evt_t set_v;

    assign set_v.lost = drop;
    assign set_v.eos  = eos_in;
    assign set_v.thr  = near_full && !nf_q;

    always_ff @(posedge clk) begin
        if (rst || flush) nf_q <= 1'b0;
        else              nf_q <= near_full;
    end

    always_ff @(posedge clk) begin
        if (rst) evt <= '0;
        else     evt <= evt_t'((evt & ~{3{stat_rd}}) | set_v);
    end

    assign irq = (fifo_ie && evt.thr) || (eos_ie && evt.eos);

    // R7
    evt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !eos_in) |=> !evt.eos);

    // R7
    evt_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && eos_in) |=> evt.eos);

    // R8
    lost_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.lost && !evt.eos && !evt.thr) |-> !irq);

endmodule

// File: rtl/sample_byte_fifo.sv
module sample_byte_fifo
    import sfifo_pkg::*;
#(
    parameter  int DEPTH_BYTES = 4096,
    localparam int BW          = $clog2(DEPTH_BYTES / 2) + 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fifo_flush,
    input  logic        acq_running,
    input  logic        smp_valid,
    input  logic [15:0] smp_data,
    input  logic        scan_end,
    input  logic        host_sel,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        irq
);

    logic          data_rd, stat_rd, data_wr, ctrl_wr;
    logic [7:0]    rd_byte;
    logic          empty, full, drop, near_full;
    logic [BW-1:0] used_bytes;
    logic          fifo_ie, eos_ie;
    evt_t          evt;
    stat_t         st;

    assign data_rd = host_rd && !host_sel;
    assign stat_rd = host_rd &&  host_sel;
    assign data_wr = host_wr && !host_sel;
    assign ctrl_wr = host_wr &&  host_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_ie <= 1'b0;
            eos_ie  <= 1'b0;
        end else if (ctrl_wr) begin
            fifo_ie <= host_wdata[CTRL_FIFO_IE_BIT];
            eos_ie  <= host_wdata[CTRL_EOS_IE_BIT];
        end
    end

    sfifo_store #(.DEPTH_BYTES(DEPTH_BYTES)) u_store (
        .clk        (clk),
        .rst        (rst),
        .flush      (fifo_flush),
        .push       (smp_valid),
        .push_data  (smp_data),
        .pop_byte   (data_rd),
        .rd_byte    (rd_byte),
        .empty      (empty),
        .full       (full),
        .drop       (drop),
        .used_bytes (used_bytes)
    );

    sfifo_thresh #(.DEPTH_BYTES(DEPTH_BYTES)) u_thresh (
        .clk        (clk),
        .rst        (rst),
        .flush      (fifo_flush),
        .wr         (data_wr),
        .wdata      (host_wdata),
        .used_bytes (used_bytes),
        .near_full  (near_full)
    );

    sfifo_events u_events (
        .clk       (clk),
        .rst       (rst),
        .flush     (fifo_flush),
        .near_full (near_full),
        .drop      (drop),
        .eos_in    (scan_end),
        .stat_rd   (stat_rd),
        .fifo_ie   (fifo_ie),
        .eos_ie    (eos_ie),
        .evt       (evt),
        .irq       (irq)
    );

    always_comb begin
        st.idle    = !acq_running;
        st.running = acq_running;
        st.lost    = evt.lost;
        st.eos     = evt.eos;
        st.thr     = evt.thr;
        st.full    = full;
        st.nfull   = near_full;
        st.empty   = empty;
    end

    assign host_rdata = host_sel ? st : rd_byte;

    // R3
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

endmodule

// File: tb/sample_byte_fifo_tb.sv
module sample_byte_fifo_tb;

    logic        clk = 1'b0;
    logic        rst, fifo_flush, acq_running, smp_valid, scan_end;
    logic [15:0] smp_data;
    logic        host_sel, host_rd, host_wr;
    logic [7:0]  host_wdata, host_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    sample_byte_fifo u_dut (
        .clk(clk), .rst(rst), .fifo_flush(fifo_flush), .acq_running(acq_running),
        .smp_valid(smp_valid), .smp_data(smp_data), .scan_end(scan_end),
        .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic push(input logic [15:0] d, input logic expect_keep);
        smp_valid = 1'b1; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
        if (expect_keep) exp_q.push_back(d);
    endtask

    task automatic hread(input logic sel, output logic [7:0] d);
        host_sel = sel; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic hwrite(input logic sel, input logic [7:0] d);
        host_sel = sel; host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic stat_chk(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        idle();
        hread(1'b1, v);
        chk(tag, v, exp);
    endtask

    // monitor side of the scoreboard: pop expected, compare both bytes
    task automatic pull_sample(input string tag);
        logic [7:0]  lo, hi;
        logic [15:0] e;
        hread(1'b0, lo);
        hread(1'b0, hi);
        e = exp_q.pop_front();
        chk(tag, {hi, lo}, e);
    endtask

    task automatic flush_fifo();
        fifo_flush = 1'b1;
        @(negedge clk);
        fifo_flush = 1'b0;
        exp_q.delete();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; fifo_flush = 0; acq_running = 0; smp_valid = 0; scan_end = 0;
        smp_data = '0; host_sel = 0; host_rd = 0; host_wr = 0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        stat_chk("R1 status after reset", 8'h81);
        chk("R1 irq after reset", irq, 1'b0);

        // R11 running/idle bits
        acq_running = 1'b1;
        stat_chk("R11 running", 8'h41);
        acq_running = 1'b0;
        stat_chk("R11 idle", 8'h81);

        // R2 order and byte sequence
        push(16'h1234, 1); push(16'hBEEF, 1); push(16'h00FF, 1);
        pull_sample("R2 sample0");
        pull_sample("R2 sample1");
        pull_sample("R2 sample2");
        stat_chk("R2 drained", 8'h81);

        // R10 empty read returns zero and changes nothing
        hread(1'b0, v);
        chk("R10 empty read data", v, 8'h00);
        push(16'hA55A, 1);
        pull_sample("R10 phase kept after empty read");

        // R12 / R7 event raised during a status read survives
        idle();
        scan_end = 1'b1;
        hread(1'b1, v);
        scan_end = 1'b0;
        chk("R7 read during event shows old", v, 8'h81);
        stat_chk("R12 eos set", 8'h91);
        stat_chk("R7 eos cleared on read", 8'h81);

        // R8 interrupt enables
        hwrite(1'b1, 8'h10);
        scan_end = 1'b1; idle(); scan_end = 1'b0;
        idle();
        chk("R8 eos irq enabled", irq, 1'b1);
        hwrite(1'b1, 8'h08);
        idle();
        chk("R8 eos irq masked", irq, 1'b0);
        hwrite(1'b1, 8'h10);
        idle();
        chk("R8 eos irq re-enabled", irq, 1'b1);
        stat_chk("R8 status with eos", 8'h91);
        chk("R8 irq drops after clear", irq, 1'b0);

        // R4 / R5 / R6 threshold programming: near-full at 4090 free bytes
        flush_fifo();
        hwrite(1'b0, 8'h00); hwrite(1'b0, 8'h00);
        hwrite(1'b0, 8'hFA); hwrite(1'b0, 8'h0F);
        hwrite(1'b0, 8'h00); hwrite(1'b0, 8'h00);
        hwrite(1'b0, 8'h00); hwrite(1'b0, 8'h00);
        hwrite(1'b1, 8'h08);
        push(16'h1111, 1); push(16'h2222, 1);
        stat_chk("R5 below threshold 4 bytes", 8'h80);
        push(16'h3333, 1);
        idle();
        chk("R8 threshold irq", irq, 1'b1);
        stat_chk("R4 R6 threshold reached 6 bytes", 8'h8A);
        chk("R8 irq cleared with thr", irq, 1'b0);
        stat_chk("R6 event cleared level held", 8'h82);
        hread(1'b0, v);
        chk("R2 low byte first", v, 8'h11);
        stat_chk("R5 half sample counts one byte", 8'h80);
        push(16'h4444, 1);
        stat_chk("R6 re-crossing fires again", 8'h8A);

        // R9 flush with a half-read sample, re-program 4094 free bytes
        flush_fifo();
        stat_chk("R9 empty after flush", 8'h81);
        hwrite(1'b0, 8'h00); hwrite(1'b0, 8'h00);
        hwrite(1'b0, 8'hFE); hwrite(1'b0, 8'h0F);
        push(16'h7788, 1);
        stat_chk("R9 threshold sequence rearmed", 8'h8A);
        pull_sample("R9 byte phase reset");

        // R3 capacity, full flag and overflow drop
        flush_fifo();
        hwrite(1'b1, 8'h18);
        for (int i = 0; i < 2048; i++) push(16'(i * 7 + 3), 1);
        stat_chk("R3 full at 2048", 8'h8E);
        push(16'hDEAD, 0);
        idle();
        chk("R8 lost does not interrupt", irq, 1'b0);
        stat_chk("R3 data lost on overflow", 8'hA6);
        for (int i = 0; i < 2048; i++) pull_sample("R3 drain after overflow");
        stat_chk("R3 empty after drain", 8'h81);
        chk("R3 scoreboard empty", exp_q.size(), 0);

        finish_run();
    end

endmodule